// File: doc/BRIEF.md
# Event Histogram Binning Controller

This block builds a two-dimensional count histogram from a stream of 48-bit detector events. Each event carries a time stamp and an energy value. The block maps the time stamp to a temporal bin and the energy to a spectral bin. It then raises that bin's counter by one with a two-cycle read-then-write into on-chip storage. Events whose energy falls outside a programmable window are taken from the input and thrown away, and they never touch storage.

The storage holds two histogram pages. One page accumulates events while the other can be read over a small register bus. A bus command exchanges the roles of the two pages. The page that takes over accumulation is zeroed before any event is counted into it, and the input stalls while that happens. The same bus also sets the spectral window, the two bin-width shifts and the readout address.

Top module: `histBinner`

## Requirements
- R1: An event on `inData` carries the time in bits [47:24] and the energy in bits [23:0]. The temporal bin is `(time >> timeShift) mod 4`. The spectral bin is `(energy - lowBound) >> energyShift`. The bin index is `temporalBin*8 + spectralBin`.
- R2: Every accepted, in-window event adds exactly one to the counter of its bin in the accumulating page. All other bins stay unchanged.
- R3: An event is discarded without changing any counter, though it is still consumed by the handshake, in any of these cases: its energy is below `lowBound`, its energy is above `highBound`, or its spectral bin would be 8 or more.
- R4: The bus registers are: address 0 `lowBound` (24 bits), address 1 `highBound` (24 bits), address 2 `timeShift` (bits [4:0]), address 3 `energyShift` (bits [3:0]). Reads of these addresses return the written values, zero-extended. Reset values are 0, all ones, 0 and 0.
- R5: Events that follow each other on consecutive cycles into the same bin are all counted.
- R6: A bin counter is 8 bits wide and holds at 255 instead of wrapping.
- R7: A bus write to address 4 with bit 0 set exchanges the accumulating and readout pages. The new accumulating page is cleared over 32 cycles, and `inReady` is low for exactly those cycles. Bus address 0x80+index reads the counter at that index in the readout page.
- R8: After reset, both pages are zero and `inReady` stays low for 64 cycles.
- R9: A bus read returns its data with `busRvalid` high in the cycle after `busRe`.
- R10: A swap command that arrives while a clear is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Event present on `inData` |
| inReady | output | 1 | Block accepts an event this cycle |
| inData | input | 48 | Event: time [47:24], energy [23:0] |
| busWe | input | 1 | Bus write strobe |
| busRe | input | 1 | Bus read strobe |
| busAddr | input | 8 | Bus address; bit 7 selects histogram readout |
| busWdata | input | 24 | Bus write data |
| busRdata | output | 24 | Bus read data |
| busRvalid | output | 1 | Read data valid |

## Verification
The bench drives two event sweeps under different window and shift settings. The first uses a narrow window with a coarse time shift, so both energy bounds and the shifted time binning are exercised. The second uses an open window with wide spectral bins, so the drop on spectral-bin overflow at energy 512 is kept apart from the drop by bounds. Exact boundary energies show whether each comparison is inclusive or exclusive. A long same-bin burst exposes a lost read-modify-write bypass and wrapping counters, while a short burst in another bin checks the bypass without saturation. Swaps are placed with and without events in flight, plus one swap during a clear, so the page-exchange and clear behaviour can be read back through the readout window.

// File: rtl/histPkg.sv
package histPkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic clrWe;    // zero one counter this cycle
    logic evtEn;    // events may be accepted
    logic accPage;  // page that currently accumulates
  } ctrlStb_t;

  // Register slots in the low bus window
  typedef enum logic [2:0] {
    REG_LOW   = 3'd0,
    REG_HIGH  = 3'd1,
    REG_TSH   = 3'd2,
    REG_ESH   = 3'd3,
    REG_CMD   = 3'd4
  } regSlot_t;

endpackage

// File: rtl/histRegs.sv
module histRegs
  import histPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 24,
  parameter int ENERGY_W = 24,
  parameter int TSH_W    = 5,
  parameter int ESH_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [ENERGY_W-1:0] loBound,
  output logic [ENERGY_W-1:0] hiBound,
  output logic [TSH_W-1:0]    tShift,
  output logic [ESH_W-1:0]    eShift,
  output logic                swapReq,
  output logic [DATA_W-1:0]   regRdata
);

  logic     regHit;
  regSlot_t regIdx;

  assign regHit = (busAddr[ADDR_W-1:3] == '0);
  assign regIdx = regSlot_t'(busAddr[2:0]);
  assign swapReq = busWe && regHit && (regIdx == REG_CMD) && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loBound <= '0;
      hiBound <= '1;
      tShift  <= '0;
      eShift  <= '0;
    end else if (busWe && regHit) begin
      case (regIdx)
        REG_LOW:  loBound <= busWdata[ENERGY_W-1:0];
        REG_HIGH: hiBound <= busWdata[ENERGY_W-1:0];
        REG_TSH:  tShift  <= busWdata[TSH_W-1:0];
        REG_ESH:  eShift  <= busWdata[ESH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (busRe) begin
      if (!regHit) begin
        regRdata <= '0;
      end else begin
        case (regIdx)
          REG_LOW:  regRdata <= DATA_W'(loBound);
          REG_HIGH: regRdata <= DATA_W'(hiBound);
          REG_TSH:  regRdata <= DATA_W'(tShift);
          REG_ESH:  regRdata <= DATA_W'(eShift);
          default:  regRdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/histCtrl.sv
module histCtrl
  import histPkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           swapReq,
  output ctrlStb_t       stb,
  output logic [IDX_W:0] clrAddr
);

  typedef enum logic {ST_CLEAR, ST_RUN} ctrlState_t;

  localparam int AW = IDX_W + 1;

  ctrlState_t    state;
  logic [AW-1:0] clrCnt;
  logic [AW-1:0] clrLast;
  logic          accPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CLEAR;     // reset sweeps both pages
      clrCnt  <= '0;
      clrLast <= '1;
      accPage <= 1'b0;
    end else begin
      case (state)
        ST_CLEAR: begin
          if (clrCnt == clrLast) state <= ST_RUN;
          else clrCnt <= clrCnt + AW'(1);
        end
        ST_RUN: begin
          if (swapReq) begin
            accPage <= ~accPage;
            clrCnt  <= {~accPage, {IDX_W{1'b0}}};
            clrLast <= {~accPage, {IDX_W{1'b1}}};
            state   <= ST_CLEAR;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end

  assign stb.clrWe   = (state == ST_CLEAR);
  assign stb.evtEn   = (state == ST_RUN);
  assign stb.accPage = accPage;
  assign clrAddr     = clrCnt;

endmodule

// File: rtl/histDatapath.sv
module histDatapath
  import histPkg::*;
#(
  parameter int EVT_W    = 48,
  parameter int TIME_W   = 24,
  parameter int ENERGY_W = 24,
  parameter int TSH_W    = 5,
  parameter int ESH_W    = 4,
  parameter int TB_BITS  = 2,
  parameter int EB_BITS  = 3,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = TB_BITS + EB_BITS,
  localparam int AW      = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic [AW-1:0]       clrAddr,
  input  logic                inValid,
  output logic                inReady,
  input  logic [EVT_W-1:0]    inData,
  input  logic [ENERGY_W-1:0] loBound,
  input  logic [ENERGY_W-1:0] hiBound,
  input  logic [TSH_W-1:0]    tShift,
  input  logic [ESH_W-1:0]    eShift,
  input  logic                rdEn,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [CNT_W-1:0]    histRdata,
  output logic                s1Valid,
  output logic                rmwWe,
  output logic [AW-1:0]       rmwAddr,
  output logic [CNT_W-1:0]    rmwData
);

  localparam int EB_CNT    = 1 << EB_BITS;
  localparam int MEM_DEPTH = 1 << AW;

  logic [CNT_W-1:0]    mem [MEM_DEPTH];
  logic [TIME_W-1:0]   timeVal;
  logic [ENERGY_W-1:0] energyVal;
  logic [ENERGY_W-1:0] eShifted;
  logic [TB_BITS-1:0]  tBin;
  logic [EB_BITS-1:0]  eBin;
  logic                inWindow;
  logic                accept;
  logic [AW-1:0]       evtAddr;
  logic [AW-1:0]       s1Addr;
  logic [CNT_W-1:0]    s1Cnt;
  logic [CNT_W-1:0]    incVal;

  // Bin mapping
  assign timeVal   = inData[EVT_W-1 -: TIME_W];
  assign energyVal = inData[ENERGY_W-1:0];
  assign tBin      = TB_BITS'(timeVal >> tShift);
  assign eShifted  = (energyVal - loBound) >> eShift;
  assign eBin      = EB_BITS'(eShifted);
  assign inWindow  = (energyVal >= loBound) && (energyVal <= hiBound) &&
                     (eShifted < ENERGY_W'(EB_CNT));
  assign evtAddr   = {stb.accPage, tBin, eBin};

  assign inReady = stb.evtEn;
  assign accept  = inValid && inReady && inWindow;

  // Stage one: fetch count, forwarding the increment still in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) s1Valid <= 1'b0;
    else       s1Valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1Addr <= evtAddr;
      s1Cnt  <= (s1Valid && (s1Addr == evtAddr)) ? incVal : mem[evtAddr];
    end
  end

  // Stage two: saturating increment and write-back
  assign incVal  = (s1Cnt == '1) ? s1Cnt : s1Cnt + CNT_W'(1);
  assign rmwWe   = s1Valid;
  assign rmwAddr = s1Addr;
  assign rmwData = incVal;

  always_ff @(posedge clk) begin
    if (stb.clrWe) mem[clrAddr] <= '0;
    if (rmwWe)     mem[rmwAddr] <= rmwData;
  end

  // Readout from the idle page
  always_ff @(posedge clk) begin
    if (rdEn) histRdata <= mem[{~stb.accPage, rdIdx}];
  end

endmodule

// File: rtl/histBinner.sv
module histBinner
  import histPkg::*;
#(
  parameter int EVT_W    = 48,
  parameter int TIME_W   = 24,
  parameter int ENERGY_W = 24,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 24,
  parameter int TSH_W    = 5,
  parameter int ESH_W    = 4,
  parameter int TB_BITS  = 2,
  parameter int EB_BITS  = 3,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [EVT_W-1:0]  inData,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid
);

  localparam int IDX_W = TB_BITS + EB_BITS;
  localparam int AW    = IDX_W + 1;

  ctrlStb_t            ctrlStb;
  logic [AW-1:0]       clrAddr;
  logic [ENERGY_W-1:0] loBound;
  logic [ENERGY_W-1:0] hiBound;
  logic [TSH_W-1:0]    tShift;
  logic [ESH_W-1:0]    eShift;
  logic                swapReq;
  logic [DATA_W-1:0]   regRdata;
  logic [CNT_W-1:0]    histRdata;
  logic                s1Valid;
  logic                rmwWe;
  logic [AW-1:0]       rmwAddr;
  logic [CNT_W-1:0]    rmwData;
  logic                rdHistSel;

  histRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENERGY_W(ENERGY_W),
    .TSH_W(TSH_W), .ESH_W(ESH_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata),
    .loBound(loBound), .hiBound(hiBound), .tShift(tShift), .eShift(eShift),
    .swapReq(swapReq), .regRdata(regRdata)
  );

  histCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .swapReq(swapReq),
    .stb(ctrlStb), .clrAddr(clrAddr)
  );

  histDatapath #(
    .EVT_W(EVT_W), .TIME_W(TIME_W), .ENERGY_W(ENERGY_W),
    .TSH_W(TSH_W), .ESH_W(ESH_W), .TB_BITS(TB_BITS),
    .EB_BITS(EB_BITS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .clrAddr(clrAddr),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .loBound(loBound), .hiBound(hiBound), .tShift(tShift), .eShift(eShift),
    .rdEn(busRe && busAddr[ADDR_W-1]), .rdIdx(busAddr[IDX_W-1:0]),
    .histRdata(histRdata), .s1Valid(s1Valid),
    .rmwWe(rmwWe), .rmwAddr(rmwAddr), .rmwData(rmwData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      rdHistSel <= 1'b0;
    end else begin
      busRvalid <= busRe;
      if (busRe) rdHistSel <= busAddr[ADDR_W-1];
    end
  end

  assign busRdata = rdHistSel ? DATA_W'(histRdata) : regRdata;

endmodule

// File: rtl/histBinnerChk.sv
module histBinnerChk #(
  parameter int ENERGY_W = 24,
  parameter int ADDR_W   = 8,
  parameter int AW       = 6,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [ENERGY_W-1:0] energy,
  input logic                busWe,
  input logic                busRe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                wBit0,
  input logic                busRvalid,
  input logic [ENERGY_W-1:0] loBound,
  input logic [ENERGY_W-1:0] hiBound,
  input logic                s1Valid,
  input logic                accPage,
  input logic                clrWe,
  input logic [AW-1:0]       clrAddr,
  input logic                rmwWe,
  input logic [AW-1:0]       rmwAddr,
  input logic [CNT_W-1:0]    rmwData
);

  logic swapCmd;
  assign swapCmd = busWe && (busAddr == ADDR_W'(4)) && wBit0;

  assert_drop_outside_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ((energy < loBound) || (energy > hiBound))) |=> !s1Valid);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    rmwWe |-> (rmwData != '0));

  assert_swap_stalls_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swapCmd && inReady) |=> !inReady);

  assert_swap_flips_page_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swapCmd && inReady) |=> (accPage != $past(accPage)));

  assert_clear_disjoint_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(clrWe && rmwWe && (clrAddr == rmwAddr)));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> busRvalid);

  assert_swap_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (swapCmd && !inReady) |=> $stable(accPage));

endmodule

bind histBinner histBinnerChk #(
  .ENERGY_W(ENERGY_W), .ADDR_W(ADDR_W), .AW(AW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .energy(inData[ENERGY_W-1:0]), .busWe(busWe), .busRe(busRe),
  .busAddr(busAddr), .wBit0(busWdata[0]), .busRvalid(busRvalid),
  .loBound(loBound), .hiBound(hiBound), .s1Valid(s1Valid),
  .accPage(ctrlStb.accPage), .clrWe(ctrlStb.clrWe), .clrAddr(clrAddr),
  .rmwWe(rmwWe), .rmwAddr(rmwAddr), .rmwData(rmwData)
);

// File: tb/histBinner_tb.sv
module histBinner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [47:0] inData = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [23:0] busWdata = '0;
  logic [23:0] busRdata;
  logic        busRvalid;

  int testCount = 0;
  int failCount = 0;
  int model [32];
  int cLo, cHi, cTs, cEs;

  always #(CLK_PERIOD/2) clk = ~clk;

  histBinner u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid)
  );

  task automatic chk(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input int data);
    busWe = 1'b1; busAddr = 8'(addr); busWdata = 24'(data);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input int addr, output int data, output bit vld);
    busRe = 1'b1; busAddr = 8'(addr);
    @(negedge clk);
    busRe = 1'b0;
    data = int'(busRdata);
    vld = busRvalid;
  endtask

  task automatic setCfg(input int lo, input int hi, input int ts, input int es);
    busWrite(0, lo); busWrite(1, hi); busWrite(2, ts); busWrite(3, es);
    cLo = lo; cHi = hi; cTs = ts; cEs = es;
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!inReady) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Expected bin update from the mapping rules (R1, R3, R6)
  task automatic modelEvt(input int t, input int e);
    int off, eb, idx;
    off = e - cLo;
    if (e >= cLo && e <= cHi) begin
      eb = off >> cEs;
      if (eb < 8) begin
        idx = ((t >> cTs) & 3) * 8 + eb;
        if (model[idx] < 255) model[idx]++;
      end
    end
  endtask

  task automatic sendEvt(input int t, input int e);
    inValid = 1'b1;
    inData = {24'(t), 24'(e)};
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    modelEvt(t, e);
  endtask

  task automatic checkPage(input string req);
    int v; bit vld;
    for (int i = 0; i < 32; i++) begin
      busRead(128 + i, v, vld);
      chk(req, v, model[i]);
    end
  endtask

  task automatic swapPages(output int n);
    busWrite(4, 1);
    waitReady(n);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : stimulus
    int n, v; bit vld;
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: stalled during the power-up clear, both pages zero afterwards
    chk("R8 ready low after reset", int'(inReady), 0);
    waitReady(n);
    chk("R8 power-up clear length", n, 64);

    // R4: reset values and readback
    busRead(1, v, vld);
    chk("R4 high bound reset", v, 24'hFFFFFF);
    setCfg(100, 300, 2, 5);
    busRead(0, v, vld); chk("R4 low bound", v, 100);
    busRead(1, v, vld); chk("R4 high bound", v, 300);
    busRead(2, v, vld); chk("R4 time shift", v, 2);
    busRead(3, v, vld); chk("R4 energy shift", v, 5);
    // R9: valid lines up with the read
    chk("R9 rvalid after read", int'(vld), 1);
    @(negedge clk);
    chk("R9 rvalid drops", int'(busRvalid), 0);
    checkPage("R8 readout page zero");

    // Sweep one: narrow window, coarse time bins (R1, R2, R3)
    for (int j = 0; j <= 200; j++) sendEvt(j * 3 + 5, j * 7);
    sendEvt(9, 99);    // R3 just below low bound
    sendEvt(9, 100);   // R1 lowest in-window energy, bin 0
    sendEvt(13, 300);  // R1 high bound is inclusive
    sendEvt(13, 301);  // R3 just above high bound
    swapPages(n);
    chk("R7 swap clear length", n, 32);
    checkPage("R2 sweep one counts");

    // Sweep two: open window, wide spectral bins, bursts (R3, R5, R6)
    for (int i = 0; i < 32; i++) model[i] = 0;
    setCfg(0, 24'hFFFFFF, 0, 6);
    for (int j = 0; j <= 240; j++) sendEvt(j, j * 3);
    sendEvt(1, 511);   // R1 top of bin 7
    sendEvt(1, 512);   // R3 spectral bin 8 is dropped
    for (int k = 0; k < 300; k++) sendEvt(2, 10);   // R6 saturation at 255
    for (int k = 0; k < 5; k++) sendEvt(3, 200);    // R5 back-to-back same bin
    chk("R6 model saturates", model[16], 255);
    busWrite(4, 1);
    chk("R7 ready low in clear", int'(inReady), 0);
    busWrite(4, 1);    // R10 swap during clear must be ignored
    waitReady(n);
    checkPage("R10 readout kept after ignored swap");

    // R7: page cleared on swap, nothing counted since
    for (int i = 0; i < 32; i++) model[i] = 0;
    swapPages(n);
    checkPage("R7 cleared page reads zero");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule